// File: doc/BRIEF.md
# DDR3 Write Burst Sequencer

This block sits on the controller side of a DDR3 interface. It carries out a single WRITE command from start to finish. A client offers a request with a ready/valid handshake. The request holds a bank, a column, a burst-length select bit and eight data words. The sequencer drives the WRITE command on the command bus for one cycle. It then waits out the write latency and drives the data strobe through three phases: preamble, toggling, and postamble. It places two data words in each command clock, one per half cycle. After the last word it counts write recovery. Only after recovery completes does it signal that a PRECHARGE to the same bank may be issued.

The burst length is decided per command. When the on-the-fly enable is high, the select bit chooses the length: select low gives a four-word chop, select high gives eight words. When the enable is low, every burst is eight words. The latency `WL_CYC` (at least 3) and the recovery count `TWR_CYC` (at least 1) are parameters.

**States:** IDLE, CMD, LAT, PRE, DATA, RECOV.

**Transitions:**
- IDLE→CMD on an accepted request.
- CMD→LAT always.
- LAT→PRE once `WL_CYC-2` cycles have passed since CMD.
- PRE→DATA always.
- DATA→RECOV after the last data cycle (2 cycles for a chop, 4 otherwise).
- RECOV→IDLE after `TWR_CYC` cycles.

Top module: `ddr3_wr_burst_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `req_ready`=1, `pre_allowed`=1, `cmd_code`=NOP (2'b00), `dqs_oe`=0 and both valid flags are 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle `cmd_code`=WRITE (2'b01) for exactly one cycle, carrying the stored bank, column and select bit. `req_ready` stays 0 until the sequencer is idle again.
- R3: The first data cycle comes `WL_CYC` cycles after the WRITE cycle.
- R4: The burst is 4 words (2 cycles) when `otf_en`=1 and `req_a12`=0 at acceptance. Otherwise it is 8 words (4 cycles); with `otf_en`=0 the select bit has no effect.
- R5: Word k of the burst is `req_data[k*DATA_W +: DATA_W]`, captured at acceptance. In data cycle j, `dq_ph0` carries word 2j and `dq_ph1` carries word 2j+1. Both valid flags are 1 in every data cycle and 0 in all other cycles.
- R6: In the cycle before the first data cycle (the preamble), `dqs_oe`=1 and `dqs_hi_ph0`=1. The strobe is high in the first half and low in the second.
- R7: In every data cycle, `dqs_oe`=1 and `dqs_hi_ph0`=1.
- R8: In the cycle after the last data cycle (the postamble), `dqs_oe`=1 and `dqs_hi_ph0`=0. In all other non-burst cycles, `dqs_oe`=0.
- R9: `pre_allowed` is 0 from the cycle after acceptance through `TWR_CYC` cycles after the last data cycle. It returns to 1, together with `req_ready`, in cycle last+1+`TWR_CYC`.
- R10: A request presented while the sequencer is busy has no effect: no extra WRITE appears, and the burst in progress keeps its own bank and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| otf_en | input | 1 | On-the-fly burst length enable, sampled at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_a12 | input | 1 | Burst-length select (0 = chop when enabled) |
| req_data | input | 8*DATA_W | Eight write words, word 0 in the low bits |
| cmd_code | output | 2 | 2'b00 NOP, 2'b01 WRITE |
| cmd_bank | output | BANK_W | Bank with WRITE, else 0 |
| cmd_col | output | COL_W | Column with WRITE, else 0 |
| cmd_a12 | output | 1 | Select bit with WRITE, else 0 |
| dqs_oe | output | 1 | Strobe driven |
| dqs_hi_ph0 | output | 1 | Strobe level in the first half cycle (second half is low) |
| dq_ph0 | output | DATA_W | Data word for the first half cycle |
| dq_ph1 | output | DATA_W | Data word for the second half cycle |
| dq_vld_ph0 | output | 1 | First-half word valid |
| dq_vld_ph1 | output | 1 | Second-half word valid |
| pre_allowed | output | 1 | PRECHARGE to the same bank permitted |

## Verification
Some rules hold on every cycle, and the assertions check those continuously. WRITE lasts a single cycle. Data never begins without a preamble cycle just before it. Each burst ends in a postamble cycle. The number of data cycles matches the chosen burst length. `pre_allowed` drops right after acceptance.

Other properties need expected values worked out by hand, so only the bench scenarios can show them. These are the exact latency from WRITE to data, the word order across half cycles, the exact cycle where recovery ends, that a busy-time request is ignored, and the mid-burst reset.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_LAT,
        ST_PRE,
        ST_DATA,
        ST_RECOV
    } wrs_state_e;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01
    } wrs_cmd_e;

    localparam int BURST_WORDS = 8;
    localparam int IDX_W       = 2;

endpackage

// File: rtl/wrs_req_store.sv
module wrs_req_store
    import wrs_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [BANK_W-1:0]             bank_in,
    input  logic [COL_W-1:0]              col_in,
    input  logic                          a12_in,
    input  logic [BURST_WORDS*DATA_W-1:0] data_in,
    input  logic [IDX_W-1:0]              cyc_idx,
    output logic [BANK_W-1:0]             bank_q,
    output logic [COL_W-1:0]              col_q,
    output logic                          a12_q,
    output logic [DATA_W-1:0]             word_even,
    output logic [DATA_W-1:0]             word_odd
);

    localparam int WSEL_W = IDX_W + 1;

    logic [BURST_WORDS*DATA_W-1:0] data_q;
    logic [DATA_W-1:0]             words [BURST_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
            a12_q  <= 1'b0;
            data_q <= '0;
        end else if (load) begin
            bank_q <= bank_in;
            col_q  <= col_in;
            a12_q  <= a12_in;
            data_q <= data_in;
        end
    end

    for (genvar g = 0; g < BURST_WORDS; g++) begin : g_unpack
        assign words[g] = data_q[g*DATA_W +: DATA_W];
    end

    always_comb begin
        word_even = words[WSEL_W'({cyc_idx, 1'b0})];
        word_odd  = words[WSEL_W'({cyc_idx, 1'b1})];
    end

endmodule

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
    import wrs_pkg::*;
#(
    parameter int WL_CYC  = 5,
    parameter int TWR_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             chop_in,
    output logic             req_ready,
    output logic             load,
    output logic             cmd_write,
    output logic             dqs_oe,
    output logic             dqs_hi_ph0,
    output logic             beat_vld,
    output logic [IDX_W-1:0] beat_idx,
    output logic             pre_allowed
);

    localparam int CNT_MAX  = (WL_CYC > TWR_CYC) ? WL_CYC : TWR_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int LAT_LOAD = WL_CYC - 3;
    localparam int REC_LOAD = TWR_CYC - 1;

    wrs_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] beat_q;
    logic             chop_q;
    logic             post_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = chop_q ? IDX_W'(1) : IDX_W'(3);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid)          st_d = ST_CMD;
            ST_CMD:                           st_d = ST_LAT;
            ST_LAT:   if (cnt_q == '0)        st_d = ST_PRE;
            ST_PRE:                           st_d = ST_DATA;
            ST_DATA:  if (beat_q == last_idx) st_d = ST_RECOV;
            ST_RECOV: if (cnt_q == '0)        st_d = ST_IDLE;
            default:                          st_d = ST_IDLE;
        endcase
    end

    // counters and burst attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            beat_q <= '0;
            chop_q <= 1'b0;
            post_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (req_valid) chop_q <= chop_in;
                ST_CMD:   cnt_q <= CNT_W'(LAT_LOAD);
                ST_LAT:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                ST_PRE:   beat_q <= '0;
                ST_DATA: begin
                    if (beat_q == last_idx) begin
                        cnt_q  <= CNT_W'(REC_LOAD);
                        post_q <= 1'b1;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                ST_RECOV: begin
                    post_q <= 1'b0;
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        pre_allowed = (st_q == ST_IDLE);
        load        = (st_q == ST_IDLE) && req_valid;
        cmd_write   = (st_q == ST_CMD);
        beat_vld    = (st_q == ST_DATA);
        beat_idx    = beat_q;
        dqs_hi_ph0  = (st_q == ST_PRE) || (st_q == ST_DATA);
        dqs_oe      = dqs_hi_ph0 || ((st_q == ST_RECOV) && post_q);
    end

    // checker: length of the current run of data cycles
    logic [2:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (beat_vld) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R2
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_write |=> (!cmd_write && !req_ready));

    // R6
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_vld) |-> $past(dqs_oe && dqs_hi_ph0));

    // R8
    postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beat_vld) |-> (dqs_oe && !dqs_hi_ph0));

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beat_vld) |-> (run_q == (chop_q ? 3'd2 : 3'd4)));

    // R9
    recov_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pre_allowed);

endmodule

// File: rtl/ddr3_wr_burst_seq.sv
module ddr3_wr_burst_seq
    import wrs_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int COL_W   = 10,
    parameter int DATA_W  = 8,
    parameter int WL_CYC  = 5,
    parameter int TWR_CYC = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          otf_en,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [BANK_W-1:0]             req_bank,
    input  logic [COL_W-1:0]              req_col,
    input  logic                          req_a12,
    input  logic [BURST_WORDS*DATA_W-1:0] req_data,
    output logic [1:0]                    cmd_code,
    output logic [BANK_W-1:0]             cmd_bank,
    output logic [COL_W-1:0]              cmd_col,
    output logic                          cmd_a12,
    output logic                          dqs_oe,
    output logic                          dqs_hi_ph0,
    output logic [DATA_W-1:0]             dq_ph0,
    output logic [DATA_W-1:0]             dq_ph1,
    output logic                          dq_vld_ph0,
    output logic                          dq_vld_ph1,
    output logic                          pre_allowed
);

    logic             load;
    logic             cmd_write;
    logic             beat_vld;
    logic [IDX_W-1:0] beat_idx;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              a12_q;
    logic [DATA_W-1:0] word_even;
    logic [DATA_W-1:0] word_odd;
    logic              chop_sel;

    assign chop_sel = otf_en && !req_a12;

    wrs_ctrl #(
        .WL_CYC  (WL_CYC),
        .TWR_CYC (TWR_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .chop_in     (chop_sel),
        .req_ready   (req_ready),
        .load        (load),
        .cmd_write   (cmd_write),
        .dqs_oe      (dqs_oe),
        .dqs_hi_ph0  (dqs_hi_ph0),
        .beat_vld    (beat_vld),
        .beat_idx    (beat_idx),
        .pre_allowed (pre_allowed)
    );

    wrs_req_store #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .bank_in   (req_bank),
        .col_in    (req_col),
        .a12_in    (req_a12),
        .data_in   (req_data),
        .cyc_idx   (beat_idx),
        .bank_q    (bank_q),
        .col_q     (col_q),
        .a12_q     (a12_q),
        .word_even (word_even),
        .word_odd  (word_odd)
    );

    always_comb begin
        cmd_code   = cmd_write ? CMD_WRITE : CMD_NOP;
        cmd_bank   = cmd_write ? bank_q : '0;
        cmd_col    = cmd_write ? col_q  : '0;
        cmd_a12    = cmd_write ? a12_q  : 1'b0;
        dq_ph0     = beat_vld ? word_even : '0;
        dq_ph1     = beat_vld ? word_odd  : '0;
        dq_vld_ph0 = beat_vld;
        dq_vld_ph1 = beat_vld;
    end

    // R5
    data_only_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_vld_ph0 |-> dqs_oe);

    // R10
    no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_WRITE) |-> $past(req_ready && req_valid));

endmodule

// File: tb/ddr3_wr_burst_seq_tb.sv
module ddr3_wr_burst_seq_tb;

    localparam int BANK_W  = 3;
    localparam int COL_W   = 10;
    localparam int DATA_W  = 8;
    localparam int WL_CYC  = 5;
    localparam int TWR_CYC = 4;
    localparam int NVEC    = 6;

    // {otf_en, a12, bank, col, seed}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd1, 10'd8,    8'h10},
        {1'b1, 1'b1, 3'd2, 10'd16,   8'h21},
        {1'b0, 1'b0, 3'd7, 10'd0,    8'h3c},
        {1'b0, 1'b1, 3'd0, 10'd1020, 8'h55},
        {1'b1, 1'b0, 3'd5, 10'd4,    8'hf0},
        {1'b1, 1'b1, 3'd3, 10'd512,  8'h0a}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  otf_en = 1'b0;
    logic                  req_valid = 1'b0;
    logic                  req_ready;
    logic [BANK_W-1:0]     req_bank = '0;
    logic [COL_W-1:0]      req_col = '0;
    logic                  req_a12 = 1'b0;
    logic [8*DATA_W-1:0]   req_data = '0;
    logic [1:0]            cmd_code;
    logic [BANK_W-1:0]     cmd_bank;
    logic [COL_W-1:0]      cmd_col;
    logic                  cmd_a12;
    logic                  dqs_oe;
    logic                  dqs_hi_ph0;
    logic [DATA_W-1:0]     dq_ph0;
    logic [DATA_W-1:0]     dq_ph1;
    logic                  dq_vld_ph0;
    logic                  dq_vld_ph1;
    logic                  pre_allowed;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ddr3_wr_burst_seq #(
        .BANK_W (BANK_W), .COL_W (COL_W), .DATA_W (DATA_W),
        .WL_CYC (WL_CYC), .TWR_CYC (TWR_CYC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .otf_en (otf_en),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_col (req_col), .req_a12 (req_a12),
        .req_data (req_data), .cmd_code (cmd_code), .cmd_bank (cmd_bank),
        .cmd_col (cmd_col), .cmd_a12 (cmd_a12), .dqs_oe (dqs_oe),
        .dqs_hi_ph0 (dqs_hi_ph0), .dq_ph0 (dq_ph0), .dq_ph1 (dq_ph1),
        .dq_vld_ph0 (dq_vld_ph0), .dq_vld_ph1 (dq_vld_ph1),
        .pre_allowed (pre_allowed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wd(input logic [7:0] s, input int k);
        return s + 8'(k * 37);
    endfunction

    function automatic logic [63:0] mk(input logic [7:0] s);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[k*8 +: 8] = wd(s, k);
        return d;
    endfunction

    // called at a falling edge while idle; returns at the falling edge where idle again
    task automatic run_burst(input logic otf, input logic a12, input logic [2:0] bank,
                             input logic [9:0] col, input logic [7:0] seed, input logic spam);
        int nclk  = (otf && !a12) ? 2 : 4;
        int first = WL_CYC;
        int last  = WL_CYC + nclk - 1;
        int endi  = last + 1 + TWR_CYC;
        otf_en    = otf;
        req_a12   = a12;
        req_bank  = bank;
        req_col   = col;
        req_data  = mk(seed);
        req_valid = 1'b1;
        chk("R2 ready before request", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i <= endi; i++) begin
            logic vld;
            logic oe_e;
            logic hi_e;
            vld  = (i >= first) && (i <= last);
            oe_e = (i >= first - 1) && (i <= last + 1);
            hi_e = (i >= first - 1) && (i <= last);
            chk(spam ? "R10 cmd code" : "R2 cmd code", 64'(cmd_code), (i == 0) ? 64'd1 : 64'd0);
            if (i == 0) begin
                chk("R2 cmd bank", 64'(cmd_bank), 64'(bank));
                chk("R2 cmd col",  64'(cmd_col),  64'(col));
                chk("R2 cmd a12",  64'(cmd_a12),  64'(a12));
            end
            chk("R9 pre_allowed", 64'(pre_allowed), 64'(i == endi));
            chk("R2 ready",       64'(req_ready),   64'(i == endi));
            chk("R3 R4 valid ph0", 64'(dq_vld_ph0), 64'(vld));
            chk("R4 valid ph1",    64'(dq_vld_ph1), 64'(vld));
            if (i == first - 1) begin
                chk("R6 preamble oe", 64'(dqs_oe), 64'd1);
                chk("R6 preamble hi", 64'(dqs_hi_ph0), 64'd1);
            end else if (vld) begin
                chk("R7 data oe", 64'(dqs_oe), 64'd1);
                chk("R7 data hi", 64'(dqs_hi_ph0), 64'd1);
                chk(spam ? "R10 word ph0" : "R5 word ph0", 64'(dq_ph0), 64'(wd(seed, 2*(i-first))));
                chk(spam ? "R10 word ph1" : "R5 word ph1", 64'(dq_ph1), 64'(wd(seed, 2*(i-first)+1)));
            end else begin
                chk("R8 strobe oe", 64'(dqs_oe), 64'(oe_e));
                chk("R8 strobe hi", 64'(dqs_hi_ph0), 64'(hi_e));
            end
            if (i == 0) begin
                req_valid = spam;
                req_bank  = ~bank;
                req_data  = ~mk(seed);
            end
            if (i == endi) req_valid = 1'b0;
            else           @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        chk("R1 ready in reset", 64'(req_ready), 64'd1);
        chk("R1 pre_allowed in reset", 64'(pre_allowed), 64'd1);
        chk("R1 cmd in reset", 64'(cmd_code), 64'd0);
        chk("R1 oe in reset", 64'(dqs_oe), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(dq_vld_ph0), 64'd0);

        for (int v = 0; v < NVEC; v++) begin
            run_burst(VEC[v][22], VEC[v][21], VEC[v][20:18], VEC[v][17:8], VEC[v][7:0], 1'b0);
        end

        // R10: request held during a busy burst is ignored
        run_burst(1'b1, 1'b0, 3'd6, 10'd40, 8'h77, 1'b1);
        run_burst(1'b1, 1'b1, 3'd4, 10'd44, 8'h99, 1'b1);

        // R1: reset in the middle of a burst
        otf_en = 1'b0; req_a12 = 1'b0; req_data = mk(8'h33); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 ready mid-burst reset", 64'(req_ready), 64'd1);
        chk("R1 oe mid-burst reset", 64'(dqs_oe), 64'd0);
        chk("R1 pre_allowed mid-burst reset", 64'(pre_allowed), 64'd1);
        chk("R1 valid mid-burst reset", 64'(dq_vld_ph0), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_burst(1'b1, 1'b0, 3'd2, 10'd100, 8'hc3, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule